// File: doc/BRIEF.md
# Raster-Aligned Trigger Synchronizer

Several devices clocked from one shared reference must begin a burst on the same sample. The trigger wire that links them arrives at each one with a delay that varies from shot to shot. This block hides that variation. Each device runs a free-running raster counter whose period is set by software. A raw trigger is not forwarded directly. It is held pending and released as a one-cycle start pulse at the next raster boundary. Any delay shorter than the raster period therefore disappears.

One device is configured as master. On the master, a software pulse arms the trigger and is also copied onto the outgoing trigger wire. Every other device is a slave. A slave passes the incoming wire through a two-flop synchronizer and arms on its rising edge. A common phase-clear input zeroes all raster counters in the same cycle. Because the devices share a clock, their counters then stay in step.

Top module: `raster_trigger_sync`

## Requirements
- R1: While reset is active and immediately after it, `start_pulse` and `line_out` are low and no trigger is pending.
- R2: The raster counter is zeroed by `phase_clr`. It then counts 0 up to `period`-1 and wraps. A raster boundary is every cycle in which the count is 0.
- R3: In master mode, `sw_fire` high at a clock edge arms the trigger at that edge. `line_out` is high for exactly the cycle that follows that edge.
- R4: In slave mode, `line_in` passes through two flops. A rising edge arms the trigger two edges after the edge that first samples `line_in` high.
- R5: When armed, `start_pulse` is high for exactly one cycle, which is the first boundary cycle at or after arming. The armed state clears with that cycle.
- R6: A trigger that arrives while one is already armed is ignored, and so is one sampled at the edge that ends the pulse cycle.
- R7: A `period` of 0 or 1 makes every cycle a boundary, so the pulse follows arming with no extra wait.
- R8: A master ignores `line_in`. A slave ignores `sw_fire` and keeps `line_out` low.
- R9: If arming lands on a boundary cycle, the pulse is issued in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared reference-derived sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_clr | input | 1 | Zeroes the raster counter to align phase across devices |
| is_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| period | input | CNT_W | Raster period in clock cycles |
| sw_fire | input | 1 | Software trigger pulse (used in master mode) |
| line_in | input | 1 | Asynchronous trigger wire from the master (used in slave mode) |
| line_out | output | 1 | Trigger wire driven toward the slaves |
| start_pulse | output | 1 | One-cycle, raster-aligned burst start |

## Verification
The bench aims triggers just before a boundary, exactly on a boundary, and just after one. An off-by-one in the counter or in the synchronizer depth would move the pulse by a whole raster period. A second software trigger is placed inside the armed window and another exactly at the edge that closes the pulse cycle. A design that re-armed too early would emit a second pulse. Periods of 0 and 1 catch an underflow in the wrap compare, which would stall the counter. Cross-mode stimulus catches a master that listens to the wire or a slave that drives it.

// File: rtl/raster_trigger_sync.sv
module raster_trigger_sync #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_clr,
  input  logic             is_master,
  input  logic [CNT_W-1:0] period,
  input  logic             sw_fire,
  input  logic             line_in,
  output logic             line_out,
  output logic             start_pulse
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       sync;
  logic             pend;
  logic             at_bnd, wrap, line_rise, raw;

  assign at_bnd      = (cnt == '0);
  assign wrap        = (period <= ONE) || (cnt >= period - ONE);
  assign line_rise   = sync[1] & ~sync[2];
  assign raw         = is_master ? sw_fire : line_rise;
  assign start_pulse = pend & at_bnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sync     <= '0;
      pend     <= 1'b0;
      line_out <= 1'b0;
    end else begin
      cnt      <= (phase_clr || wrap) ? '0 : cnt + ONE;
      sync     <= {sync[1:0], line_in};
      pend     <= start_pulse ? 1'b0 : (pend | raw);
      line_out <= is_master & sw_fire;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R5
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !pend); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> at_bnd); // R2
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> !line_out); // R8
  AST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !pend) |=> pend); // R3
  AST_WAIT_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !at_bnd) |=> pend); // R5
  AST_FAST_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    (period <= ONE && !phase_clr) |=> at_bnd); // R7

endmodule

// File: tb/tb_raster_trigger_sync.sv
`timescale 1ns/1ps
module tb_raster_trigger_sync;
  localparam int W = 16;
  localparam int NV = 11;
  localparam int LIM = 40;
  // period, master, first trigger edge, second trigger edge (0 none),
  // expected first pulse edge, expected pulse count
  localparam int VEC [NV][6] = '{
    '{8, 1, 3, 0,  8, 1},
    '{8, 1, 8, 0,  8, 1},
    '{8, 1, 9, 0, 16, 1},
    '{5, 0, 1, 0,  5, 1},
    '{5, 0, 3, 0,  5, 1},
    '{5, 0, 4, 0, 10, 1},
    '{1, 1, 6, 0,  6, 1},
    '{0, 0, 2, 0,  4, 1},
    '{8, 1, 2, 5,  8, 1},
    '{8, 1, 2, 9,  8, 1},
    '{4, 1, 2, 10, 4, 2}
  };

  logic clk = 0, rst_n = 0, phase_clr = 0, is_master = 0, sw_fire = 0, line_in = 0;
  logic [W-1:0] period = '0;
  logic line_out, start_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  raster_trigger_sync #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .phase_clr(phase_clr), .is_master(is_master),
    .period(period), .sw_fire(sw_fire), .line_in(line_in),
    .line_out(line_out), .start_pulse(start_pulse));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int p, input int m, input int d, input int d2,
                     output int first, output int np, output int lo_first, output int nlo);
    period = W'(p); is_master = m[0];
    phase_clr = 1;
    @(posedge clk); #1 phase_clr = 0;
    first = -1; np = 0; lo_first = -1; nlo = 0;
    for (int e = 1; e <= LIM; e++) begin
      sw_fire = (e == d) || (d2 != 0 && e == d2);
      if (e == d) line_in = 1;
      if (e == d + 3) line_in = 0;
      @(posedge clk); #1;
      sw_fire = 0;
      if (start_pulse) begin np++; if (first < 0) first = e; end
      if (line_out) begin nlo++; if (lo_first < 0) lo_first = e; end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int f, n, lf, nl;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 start_pulse in reset", start_pulse, 0);
    chk("R1 line_out in reset", line_out, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 start_pulse after reset", start_pulse, 0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], f, n, lf, nl);
      // R2 R4 R5 R7 R9: first pulse edge
      chk($sformatf("R5 vec%0d first pulse edge", i), f, VEC[i][4]);
      // R6: pulse count
      chk($sformatf("R6 vec%0d pulse count", i), n, VEC[i][5]);
      if (VEC[i][1] == 1) begin
        chk($sformatf("R3 vec%0d line_out edge", i), lf, VEC[i][2]);
        chk($sformatf("R3 vec%0d line_out count", i), nl, VEC[i][3] != 0 ? 2 : 1);
      end else begin
        chk($sformatf("R8 vec%0d slave line_out", i), nl, 0);
      end
    end

    // R8: master ignores the wire
    period = W'(4); is_master = 1; n = 0;
    for (int e = 0; e < 24; e++) begin
      line_in = e[2];
      @(posedge clk); #1;
      if (start_pulse) n++;
    end
    line_in = 0;
    chk("R8 master ignores line_in", n, 0);

    // R8: slave ignores software trigger
    is_master = 0; n = 0; nl = 0;
    for (int e = 0; e < 24; e++) begin
      sw_fire = (e % 5 == 0);
      @(posedge clk); #1;
      if (start_pulse) n++;
      if (line_out) nl++;
    end
    sw_fire = 0;
    chk("R8 slave ignores sw_fire", n, 0);
    chk("R8 slave line_out low", nl, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule